// File: doc/BRIEF.md
# Instruction-Pair Exception Priority Resolver

This block picks the single exception that a commit stage accepts from all the exception flags raised by the instruction being retired. It works in two modes. In single mode, one ordinary instruction of up to two memory data transfers is judged on its own. In pair mode, a delayed branch and its delay slot instruction retire as one indivisible unit, and their flags are merged into one cross-instruction ranking. That ranking is grouped by exception level and type. It is not a flat encoder.

Each instruction presents a 12-bit flag word. The result is a hit flag, a 4-bit cause code, the owning instruction, the transfer index and a one-hot accept vector over all 24 input flags. It also carries two link-register controls for a branch that is a subroutine call. The request enters through a valid/ready handshake. With the default `OUT_REG = 1`, the result leaves through a one-entry output register. That register holds its content while `out_ready` is low, and `in_ready` drops while the register is full and not being drained. With `OUT_REG = 0`, the block is purely combinational and the handshake passes straight through.

Top module: `exc_pair_resolver`

## Requirements
- R1: Flag word bits are: bit 0 interrupt type, bits 1-4 transfer-1 address error / TLB miss / protection violation / first-page-write, bits 5-8 the same four for transfer 2, bit 9 completion type at level 2, bit 10 level 3, bit 11 level 4. In single mode (`pair_mode = 0`) the set branch-word bit of lowest index is accepted.
- R2: In both modes, any transfer-1 fault of an instruction outranks every transfer-2 fault of the same instruction.
- R3: In pair mode, any branch flag in bits 0-8 outranks every delay slot flag, and delay slot bits 0-8 outrank every other remaining flag; within each word the lowest index wins.
- R4: In pair mode, with bits 0-8 clear in both words, the branch completion flag wins, then the delay slot completion flag.
- R5: In pair mode, with bits 0-9 clear in both words, level 3 of either instruction outranks level 4 of either instruction. When both instructions raise the same level, the branch wins if `SLOT_WINS_TIE = 0` and the delay slot wins if it is 1.
- R6: The cause codes are: 0 none, 1 interrupt, 2 address error, 3 TLB miss, 4 protection, 5 first-page-write, 6 completion, 7 level 3, 8 level 4. `exc_src` is 0 for the branch and 1 for the delay slot. `exc_xfer` is 1 only for a transfer-2 fault.
- R7: `exc_accept` has at most one bit set. Bits 11:0 map to the branch word and bits 23:12 to the slot word. With no flag set, every result output is zero. In single mode the slot word has no effect.
- R8: If the accepted exception is a delay slot transfer fault (cause 2-5, source 1), `link_wr_suppress` is 0 and `link_unreliable` equals `br_is_call`. Otherwise `link_unreliable` is 0 and `link_wr_suppress` equals `exc_hit` AND `br_is_call`.
- R9: With `OUT_REG = 1`, a request taken while `in_valid` and `in_ready` are both high is presented on `out_valid` and the result outputs one cycle later. The result holds unchanged while `out_ready` is low. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: After reset, `out_valid` and all result outputs are zero and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| pair_mode | input | 1 | 1 = branch plus delay slot unit, 0 = single instruction |
| br_is_call | input | 1 | Branch (or single instruction) writes the return address |
| br_flags | input | 12 | Branch / single instruction flag word |
| ds_flags | input | 12 | Delay slot flag word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| exc_hit | output | 1 | An exception was accepted |
| exc_cause | output | 4 | Cause code |
| exc_src | output | 1 | Owning instruction |
| exc_xfer | output | 1 | Transfer index of a memory fault |
| exc_accept | output | 24 | One-hot accepted flag |
| link_wr_suppress | output | 1 | Block the link-register write |
| link_unreliable | output | 1 | Link-register value not guaranteed |

## Verification
Every result is due exactly one clock after the edge that takes the request. The bench drives each request on a falling edge and samples all outputs on the next falling edge. That point lies after the capturing rising edge and clear of the following one. In the back-pressure case, the request that is stalled behind a held result is sampled on each falling edge while `out_ready` is low. It is then sampled once more one cycle after release, which is when the second result becomes due.

// File: rtl/exc_pair_pkg.sv
package exc_pair_pkg;
  localparam int FLAG_W      = 12;
  localparam int XFER_CAUSES = 4;
  localparam int BIT_IRQ     = 0;
  localparam int BIT_X0      = 1;
  localparam int BIT_X1      = BIT_X0 + XFER_CAUSES;
  localparam int BIT_CMP     = BIT_X1 + XFER_CAUSES;
  localparam int BIT_L3      = BIT_CMP + 1;
  localparam int BIT_L4      = BIT_L3 + 1;
  localparam int EARLY_N     = BIT_CMP;
  localparam int IDX_W       = $clog2(FLAG_W);
  localparam int ACC_W       = 2 * FLAG_W;

  typedef enum logic [3:0] {
    C_NONE    = 4'd0,
    C_IRQ     = 4'd1,
    C_ADDR    = 4'd2,
    C_TLBMISS = 4'd3,
    C_PROT    = 4'd4,
    C_FIRSTWR = 4'd5,
    C_COMPL   = 4'd6,
    C_LVL3    = 4'd7,
    C_LVL4    = 4'd8
  } cause_e;

  typedef struct packed {
    logic             hit;
    cause_e           cause;
    logic             src;
    logic             xfer;
    logic [ACC_W-1:0] accept;
    logic             link_sup;
    logic             link_unrel;
  } result_t;

  function automatic cause_e idx_cause(input logic [IDX_W-1:0] idx);
    int k;
    k = int'(idx);
    if (k == BIT_IRQ)                       return C_IRQ;
    if (k >= BIT_X0 && k < BIT_CMP)         return cause_e'(4'(int'(C_ADDR) + ((k - BIT_X0) % XFER_CAUSES)));
    if (k == BIT_CMP)                       return C_COMPL;
    if (k == BIT_L3)                        return C_LVL3;
    return C_LVL4;
  endfunction

  function automatic logic idx_xfer(input logic [IDX_W-1:0] idx);
    return (int'(idx) >= BIT_X1) && (int'(idx) < BIT_CMP);
  endfunction
endpackage

// File: rtl/exc_inst_rank.sv
module exc_inst_rank
  import exc_pair_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output logic              early_hit,
  output logic [IDX_W-1:0]  early_idx,
  output logic              any_hit,
  output logic [IDX_W-1:0]  any_idx
);
  always_comb begin
    early_hit = 1'b0;
    early_idx = '0;
    for (int i = EARLY_N - 1; i >= 0; i--) begin
      if (flags[i]) begin
        early_hit = 1'b1;
        early_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    any_hit = 1'b0;
    any_idx = '0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (flags[i]) begin
        any_hit = 1'b1;
        any_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_pair_merge.sv
module exc_pair_merge
  import exc_pair_pkg::*;
#(
  parameter bit SLOT_WINS_TIE = 1'b0
) (
  input  logic              pair_mode,
  input  logic              br_is_call,
  input  logic [FLAG_W-1:0] br_flags,
  input  logic [FLAG_W-1:0] ds_flags,
  output result_t           res
);
  logic [1:0][FLAG_W-1:0] word;
  logic [1:0]             e_hit, a_hit;
  logic [1:0][IDX_W-1:0]  e_idx, a_idx;

  assign word[0] = br_flags;
  assign word[1] = pair_mode ? ds_flags : '0;

  for (genvar g = 0; g < 2; g++) begin : g_rank
    exc_inst_rank u_rank (
      .flags     (word[g]),
      .early_hit (e_hit[g]),
      .early_idx (e_idx[g]),
      .any_hit   (a_hit[g]),
      .any_idx   (a_idx[g])
    );
  end

  logic             hit, src;
  logic [IDX_W-1:0] idx;
  logic             slot_reexec;
  cause_e           cause;

  always_comb begin
    hit = 1'b1;
    src = 1'b0;
    idx = '0;
    if (!pair_mode) begin
      hit = a_hit[0];
      idx = a_idx[0];
    end else if (e_hit[0]) begin
      idx = e_idx[0];
    end else if (e_hit[1]) begin
      src = 1'b1;
      idx = e_idx[1];
    end else if (word[0][BIT_CMP]) begin
      idx = IDX_W'(BIT_CMP);
    end else if (word[1][BIT_CMP]) begin
      src = 1'b1;
      idx = IDX_W'(BIT_CMP);
    end else if (word[0][BIT_L3] || word[1][BIT_L3]) begin
      src = (word[0][BIT_L3] && word[1][BIT_L3]) ? SLOT_WINS_TIE : word[1][BIT_L3];
      idx = IDX_W'(BIT_L3);
    end else if (word[0][BIT_L4] || word[1][BIT_L4]) begin
      src = (word[0][BIT_L4] && word[1][BIT_L4]) ? SLOT_WINS_TIE : word[1][BIT_L4];
      idx = IDX_W'(BIT_L4);
    end else begin
      hit = 1'b0;
    end
  end

  assign cause       = hit ? idx_cause(idx) : C_NONE;
  assign slot_reexec = hit && src && (cause >= C_ADDR) && (cause <= C_FIRSTWR);

  always_comb begin
    res            = '0;
    res.hit        = hit;
    res.cause      = cause;
    res.src        = hit & src;
    res.xfer       = hit & idx_xfer(idx);
    res.accept     = hit ? (ACC_W'(1) << (int'(idx) + (src ? FLAG_W : 0))) : '0;
    res.link_sup   = hit && br_is_call && !slot_reexec;
    res.link_unrel = slot_reexec && br_is_call;
  end
endmodule

// File: rtl/exc_out_stage.sv
module exc_out_stage
  import exc_pair_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  result_t res_i,
  output logic    out_valid,
  input  logic    out_ready,
  output result_t res_o
);
  if (OUT_REG) begin : g_reg
    logic    vld_q;
    result_t res_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign res_o     = res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= res_i;
      end
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(res_o));
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign res_o     = res_i;
  end
endmodule

// File: rtl/exc_pair_resolver.sv
module exc_pair_resolver
  import exc_pair_pkg::*;
#(
  parameter bit OUT_REG       = 1'b1,
  parameter bit SLOT_WINS_TIE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pair_mode,
  input  logic              br_is_call,
  input  logic [FLAG_W-1:0] br_flags,
  input  logic [FLAG_W-1:0] ds_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              exc_hit,
  output logic [3:0]        exc_cause,
  output logic              exc_src,
  output logic              exc_xfer,
  output logic [ACC_W-1:0]  exc_accept,
  output logic              link_wr_suppress,
  output logic              link_unreliable
);
  result_t merged, held;

  exc_pair_merge #(.SLOT_WINS_TIE(SLOT_WINS_TIE)) u_merge (
    .pair_mode  (pair_mode),
    .br_is_call (br_is_call),
    .br_flags   (br_flags),
    .ds_flags   (ds_flags),
    .res        (merged)
  );

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(merged.accept));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !merged.hit |-> (merged.accept == '0) && (merged.cause == C_NONE) && !merged.link_sup);
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |-> (merged.accept[ACC_W-1:FLAG_W] == '0));
  a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
    !(merged.link_sup && merged.link_unrel));
  a_r2_first_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (br_flags[BIT_X1 +: XFER_CAUSES] != '0) && (br_flags[BIT_IRQ +: BIT_X1] != '0) |-> !merged.accept[BIT_X1 +: XFER_CAUSES]);

  exc_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_i     (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_o     (held)
  );

  assign exc_hit          = held.hit;
  assign exc_cause        = held.cause;
  assign exc_src          = held.src;
  assign exc_xfer         = held.xfer;
  assign exc_accept       = held.accept;
  assign link_wr_suppress = held.link_sup;
  assign link_unreliable  = held.link_unrel;
endmodule

// File: tb/test_exc_pair_resolver.sv
module test_exc_pair_resolver;
  localparam int  W   = 12;
  localparam bit  TIE = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, pair_mode = 1'b0, br_is_call = 1'b0;
  logic [W-1:0] br_flags = '0, ds_flags = '0;
  logic in_ready, out_valid, exc_hit, exc_src, exc_xfer, link_wr_suppress, link_unreliable;
  logic [3:0] exc_cause;
  logic [2*W-1:0] exc_accept;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  exc_pair_resolver #(.OUT_REG(1'b1), .SLOT_WINS_TIE(TIE)) i_exc_pair_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pair_mode(pair_mode), .br_is_call(br_is_call), .br_flags(br_flags), .ds_flags(ds_flags),
    .out_valid(out_valid), .out_ready(out_ready), .exc_hit(exc_hit), .exc_cause(exc_cause),
    .exc_src(exc_src), .exc_xfer(exc_xfer), .exc_accept(exc_accept),
    .link_wr_suppress(link_wr_suppress), .link_unreliable(link_unreliable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result: {hit, cause, src, xfer, accept, sup, unrel}; step names the rule that decided
  logic        e_hit, e_src, e_xfer, e_sup, e_unrel;
  logic [3:0]  e_cause;
  logic [23:0] e_acc;
  string       e_tag;

  task automatic pick(input bit s, input int b, input string tag);
    if (!e_hit) begin
      e_hit = 1'b1; e_src = s; e_tag = tag;
      e_acc = 24'(1) << (b + (s ? W : 0));
      if (b == 0) begin e_cause = 4'd1; e_xfer = 1'b0; end
      else if (b <= 8) begin e_cause = 4'(2 + (b - 1) % 4); e_xfer = ((b - 1) / 4) == 1; end
      else e_cause = 4'(b - 3);
    end
  endtask

  task automatic model(input bit pm, input bit call, input logic [W-1:0] b, input logic [W-1:0] d);
    e_hit = 0; e_src = 0; e_xfer = 0; e_cause = 0; e_acc = 0; e_tag = "R7";
    if (!pm) begin
      for (int i = 0; i < W; i++) if (b[i]) pick(1'b0, i, "R1");
    end else begin
      for (int i = 0; i < 9; i++) if (b[i]) pick(1'b0, i, "R3");
      for (int i = 0; i < 9; i++) if (d[i]) pick(1'b1, i, "R3");
      if (b[9]) pick(1'b0, 9, "R4");
      if (d[9]) pick(1'b1, 9, "R4");
      for (int l = 10; l < 12; l++) begin
        if (b[l] && d[l]) pick(TIE, l, "R5");
        else if (b[l]) pick(1'b0, l, "R5");
        else if (d[l]) pick(1'b1, l, "R5");
      end
    end
    e_unrel = e_hit && e_src && e_cause >= 2 && e_cause <= 5 && call;
    e_sup   = e_hit && call && !(e_src && e_cause >= 2 && e_cause <= 5);
  endtask

  task automatic compare();
    chk({e_tag, " order"}, {exc_hit, exc_src, exc_accept}, {e_hit, e_src, e_acc});
    chk("R6 code", {exc_cause, exc_xfer}, {e_cause, e_xfer});
    chk("R8 link", {link_wr_suppress, link_unreliable}, {e_sup, e_unrel});
  endtask

  // drive on a falling edge, result due one rising edge later: sample next falling edge
  task automatic run(input bit pm, input bit call, input logic [W-1:0] b, input logic [W-1:0] d);
    in_valid = 1; pair_mode = pm; br_is_call = call; br_flags = b; ds_flags = d;
    @(negedge clk);
    in_valid = 0;
    chk("R9 valid", out_valid, 1'b1);
    model(pm, call, b, d);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 reset", {out_valid, exc_hit, exc_cause, exc_accept, link_wr_suppress, link_unreliable}, '0);
    chk("R10 ready", in_ready, 1'b1);
    rst_n = 1;
    @(negedge clk);

    // directed: R2 transfer order in both modes
    run(1'b0, 1'b0, 12'h020 | 12'h010, '0);   // x2 addr + x1 first-page-write
    chk("R2 single", exc_accept, 24'h000010);
    run(1'b1, 1'b0, '0, 12'h022);             // slot x2 addr + slot x1 addr
    chk("R2 pair", {exc_accept, exc_xfer}, {24'h002000, 1'b0});
    // R5 tie on level 3 and level 4
    run(1'b1, 1'b0, 12'h400, 12'h400);
    chk("R5 tie l3", exc_src, TIE);
    run(1'b1, 1'b0, 12'h800, 12'h400);
    chk("R5 l3 over l4", {exc_src, exc_cause}, {1'b1, 4'd7});
    // R7 slot word ignored in single mode; empty words give zero
    run(1'b0, 1'b1, '0, 12'hFFF);
    chk("R7 ignored", {exc_hit, exc_accept, link_wr_suppress}, '0);
    // R8 slot re-execution with call
    run(1'b1, 1'b1, 12'h200, 12'h004);
    chk("R8 slot reexec", {link_wr_suppress, link_unreliable}, 2'b01);

    // R9 back-pressure
    in_valid = 1; pair_mode = 1; br_is_call = 0; br_flags = 12'h001; ds_flags = 0;
    @(negedge clk);
    out_ready = 0; br_flags = 12'h800;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 hold", {out_valid, in_ready, exc_cause}, {1'b1, 1'b0, 4'd1});
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R9 next", {out_valid, exc_cause}, {1'b1, 4'd8});
    @(negedge clk);
    chk("R9 drain", {out_valid, in_ready}, 2'b01);

    // sweep of every single flag and every pair of flags over both modes and call values
    for (int i = 0; i < 2 * W; i++)
      for (int j = i; j < 2 * W; j++)
        for (int m = 0; m < 4; m++) begin
          logic [2*W-1:0] v;
          v = (24'(1) << i) | (24'(1) << j);
          run(m[0], m[1], v[W-1:0], v[2*W-1:W]);
        end

    // dense random words
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r1, r2;
      r1 = $urandom & $urandom & $urandom;
      r2 = $urandom & $urandom;
      run(r2[31], r2[30], r1[W-1:0], r1[2*W-1:W]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule